// File: doc/BRIEF.md
# Indirect Table Port with Auto-Advancing Pointers

This block lets a bus slave reach a large internal table space through a small window of directly addressed ports. Software first loads an index into a pointer port. It then reads or writes a data port, and that access lands on the location the pointer names. After each data access the pointer moves on to the next location, so a run of neighbouring entries can be streamed with one pointer load followed by repeated data accesses.

Two pointer pairs exist, one for each state set. Each pair has a 16-bit wide pointer and an 8-bit colour-converter pointer. The 16-bit space decodes into five kinds of target:
- three image colour tables, held in two timing banks plus a shadow copy;
- six fast-clear colours, held in two banks plus a shadow;
- window-ID tables, held in five banks plus a shadow;
- a few control words.

Reserved indices are acknowledged and otherwise ignored. A write-all-banks input lets one data write refresh every bank copy of an entry.

The 8-bit pointer indexes a 256-entry colour-converter table. In 24-bit mode, one 4-byte transfer moves one entry. In 30-bit mode, each entry moves as two 2-byte transfers. A small per-state-set sequencer tracks which half comes next, using two states:
- `PH_LO` is the first half. A 30-bit data transfer moves it to `PH_HI`.
- `PH_HI` is the second half. The second transfer returns it to `PH_LO`, and so does a pointer write.

In 24-bit mode the sequencer stays in `PH_LO`.

Top module: `ixp_port`

## Requirements
- R1: Every access (bus_valid high at a rising edge) is answered by bus_ack high in the following cycle, including accesses to reserved indices. bus_ack is low in cycles that follow no access. bus_rdata changes only after a read.
- R2: The port is chosen by bus_sel: 0 is the wide pointer, 1 is wide data, 2 is the converter pointer and 3 is converter data. Writing port 0 loads bus_wdata[15:0] into the wide pointer of the state set chosen by bus_sset. Reading port 0 returns that pointer zero-extended. Each state set's pointers are untouched by accesses made under the other state set.
- R3: A wide data access targets the location named by the wide pointer. After the access the pointer increments by one, wrapping from 0xFFFF to 0x0000.
- R4: Colour entries (image tables, fast-clear colours and their shadows) are 24 bits wide. A write takes the entry from bus bytes 3, 2, 1 (bus_wdata[31:8]). A read returns the entry in bus_rdata[31:8] with bits 7:0 zero.
- R5: Image table t (0 to 2), bank b (0 or 1), word w lives at index 0x3000 + b*0x400 + t*0x100 + w, for w below CLUT_WORDS. Its shadow word w lives at 0x4000 + w. Each bank and the shadow are separate storage.
- R6: Fast-clear colour i (0 to 5) lives at 0x3300 + i in bank 0, at 0x3700 + i in bank 1, and at 0x4100 + i in the shadow.
- R7: Window-ID entry e (below 80) of bank b (0 to 4) lives at 0x5000 + b*0x100 + e. Entries 0 to 63 form the primary table and entries 64 to 79 the secondary table. Shadow entry e lives at 0x5800 + e. Entries are 10 bits wide in bus bits 9:0, and the upper bits read as zero.
- R8: Control word i (0 to 7) lives at 0x2000 + i. It is 16 bits wide in bus bits 15:0, and the upper bits read as zero.
- R9: While bank_all is high, a data write to any banked index writes that entry in every bank of its table. Shadow copies are not affected. While bank_all is low, only the addressed bank changes.
- R10: An index outside R5 to R8 is reserved. A write to it changes no storage, a read of it returns zero, and the pointer still advances.
- R11: Writing port 2 loads the converter pointer and restarts the half sequence. Reading port 2 returns the pointer. With dac_mode30 low, one port-3 transfer moves one entry: a write stores bus_wdata[31:8] with entry bits 29:24 zero, and a read returns entry bits 23:0 in bus_rdata[31:8]. The pointer then increments, wrapping from 255 to 0.
- R12: With dac_mode30 high, a 30-bit entry moves in two port-3 transfers. The first carries entry bits 15:0 in bus bits 15:0. The second carries entry bits 29:16 in bus bits 13:0. A write takes effect on the second transfer, and the pointer advances only after the second transfer.
- R13: A 30-bit read captures the whole entry on its first transfer. The second transfer returns the high part of that captured value even if the entry was rewritten in between.
- R14: After reset, all pointers, bus_rdata, bus_ack and all table storage are zero, and the half sequence is in `PH_LO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sset | input | 1 | State set of this access |
| bus_sel | input | 2 | Port select (R2 encoding) |
| bus_wdata | input | 32 | Write data |
| bank_all | input | 1 | Write every bank copy of a banked entry |
| dac_mode30 | input | 1 | 1 = 30-bit two-transfer converter entries |
| bus_ack | output | 1 | Access acknowledge, one cycle after the access |
| bus_rdata | output | 32 | Read data, valid alongside bus_ack after a read |

## Verification
The bench fills the whole index range 0x2000 to 0x5FFF with a hashed pattern and reads it back. A decoder that aliased a reserved or shadow index onto live storage would corrupt a live entry. One that mis-sized a table would either return zero where data belongs or return data at a reserved index. The pointer-wrap checks cover 0xFFFF to 0 for the wide pointer and 255 to 0 for the converter pointer, with 30-bit entries written across the wrap. These catch a pointer that advances after the first half or a sequencer that loses its phase. The coherence test rewrites a converter entry from the other state set between the two halves of a read. A design that re-fetched the entry for the second half would return the new high bits instead of the captured ones.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

    typedef enum logic [1:0] {
        SEL_WPTR  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_DPTR  = 2'd2,
        SEL_DDATA = 2'd3
    } port_sel_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_CLUT,
        RG_CLUT_SH,
        RG_FCLR,
        RG_FCLR_SH,
        RG_WID,
        RG_WID_SH
    } region_e;

    typedef enum logic {
        PH_LO,
        PH_HI
    } phase_e;

    typedef struct packed {
        region_e    region;
        logic [2:0] bank;
        logic [1:0] tbl;
        logic [7:0] off;
    } target_t;

    localparam int STATE_SETS  = 2;
    localparam int CLUT_TABLES = 3;
    localparam int CLUT_BANKS  = 2;

endpackage

// File: rtl/ixp_decode.sv
module ixp_decode
    import ixp_pkg::*;
#(
    parameter int CLUT_WORDS = 32,
    parameter int FCLR_WORDS = 6,
    parameter int WID_WORDS  = 80,
    parameter int WID_BANKS  = 5,
    parameter int CTRL_WORDS = 8
) (
    input  logic [15:0] idx,
    output target_t     tgt
);

    int off_i;

    always_comb begin
        off_i      = int'(idx[7:0]);
        tgt.region = RG_NONE;
        tgt.bank   = '0;
        tgt.tbl    = '0;
        tgt.off    = idx[7:0];
        if (idx[15:8] == 8'h20) begin
            if (off_i < CTRL_WORDS) tgt.region = RG_CTRL;
        end else if (idx[15:12] == 4'h3 && !idx[11]) begin
            tgt.bank = {2'b00, idx[10]};
            tgt.tbl  = idx[9:8];
            if (int'(idx[9:8]) < CLUT_TABLES) begin
                if (off_i < CLUT_WORDS) tgt.region = RG_CLUT;
            end else begin
                if (off_i < FCLR_WORDS) tgt.region = RG_FCLR;
            end
        end else if (idx[15:8] == 8'h40) begin
            if (off_i < CLUT_WORDS) tgt.region = RG_CLUT_SH;
        end else if (idx[15:8] == 8'h41) begin
            if (off_i < FCLR_WORDS) tgt.region = RG_FCLR_SH;
        end else if (idx[15:11] == 5'b01010) begin
            tgt.bank = idx[10:8];
            if (int'(idx[10:8]) < WID_BANKS && off_i < WID_WORDS) tgt.region = RG_WID;
        end else if (idx[15:8] == 8'h58) begin
            if (off_i < WID_WORDS) tgt.region = RG_WID_SH;
        end
    end

endmodule

// File: rtl/ixp_tables.sv
module ixp_tables
    import ixp_pkg::*;
#(
    parameter int CLUT_WORDS = 32,
    parameter int FCLR_WORDS = 6,
    parameter int WID_WORDS  = 80,
    parameter int WID_BANKS  = 5,
    parameter int CTRL_WORDS = 8,
    parameter int DAC_WORDS  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  target_t     tgt,
    input  logic        all_banks,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        dac_we,
    input  logic [7:0]  dac_idx,
    input  logic [29:0] dac_wval,
    output logic [29:0] dac_rval
);

    localparam int CLUT_BANK_WORDS = CLUT_TABLES * CLUT_WORDS;
    localparam int CLW = $clog2(CLUT_BANK_WORDS);
    localparam int CSW = $clog2(CLUT_WORDS);
    localparam int FW  = $clog2(FCLR_WORDS);
    localparam int WW  = $clog2(WID_WORDS);
    localparam int CTW = $clog2(CTRL_WORDS);
    localparam int DW  = $clog2(DAC_WORDS);

    logic [23:0] clut_q    [CLUT_BANKS][CLUT_BANK_WORDS];
    logic [23:0] clut_sh_q [CLUT_WORDS];
    logic [23:0] fclr_q    [CLUT_BANKS][FCLR_WORDS];
    logic [23:0] fclr_sh_q [FCLR_WORDS];
    logic [9:0]  wid_q     [WID_BANKS][WID_WORDS];
    logic [9:0]  wid_sh_q  [WID_WORDS];
    logic [15:0] ctrl_q    [CTRL_WORDS];
    logic [29:0] dac_q     [DAC_WORDS];

    logic [CLW-1:0] clut_i;
    logic [CSW-1:0] clsh_i;
    logic [FW-1:0]  fc_i;
    logic [WW-1:0]  wid_i;
    logic [CTW-1:0] ctrl_i;
    logic           dac_ok;

    assign clut_i = CLW'(int'(tgt.tbl) * CLUT_WORDS + int'(tgt.off));
    assign clsh_i = CSW'(tgt.off);
    assign fc_i   = FW'(tgt.off);
    assign wid_i  = WW'(tgt.off);
    assign ctrl_i = CTW'(tgt.off);
    assign dac_ok = int'(dac_idx) < DAC_WORDS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < CLUT_BANKS; b++) begin
                for (int i = 0; i < CLUT_BANK_WORDS; i++) clut_q[b][i] <= '0;
                for (int i = 0; i < FCLR_WORDS; i++) fclr_q[b][i] <= '0;
            end
            for (int i = 0; i < CLUT_WORDS; i++) clut_sh_q[i] <= '0;
            for (int i = 0; i < FCLR_WORDS; i++) fclr_sh_q[i] <= '0;
            for (int b = 0; b < WID_BANKS; b++)
                for (int i = 0; i < WID_WORDS; i++) wid_q[b][i] <= '0;
            for (int i = 0; i < WID_WORDS; i++) wid_sh_q[i] <= '0;
            for (int i = 0; i < CTRL_WORDS; i++) ctrl_q[i] <= '0;
            for (int i = 0; i < DAC_WORDS; i++) dac_q[i] <= '0;
        end else begin
            if (we) begin
                unique case (tgt.region)
                    RG_CTRL:    ctrl_q[ctrl_i] <= wdata[15:0];
                    RG_CLUT: begin
                        for (int b = 0; b < CLUT_BANKS; b++)
                            if (all_banks || b == int'(tgt.bank)) clut_q[b][clut_i] <= wdata[31:8];
                    end
                    RG_CLUT_SH: clut_sh_q[clsh_i] <= wdata[31:8];
                    RG_FCLR: begin
                        for (int b = 0; b < CLUT_BANKS; b++)
                            if (all_banks || b == int'(tgt.bank)) fclr_q[b][fc_i] <= wdata[31:8];
                    end
                    RG_FCLR_SH: fclr_sh_q[fc_i] <= wdata[31:8];
                    RG_WID: begin
                        for (int b = 0; b < WID_BANKS; b++)
                            if (all_banks || b == int'(tgt.bank)) wid_q[b][wid_i] <= wdata[9:0];
                    end
                    RG_WID_SH:  wid_sh_q[wid_i] <= wdata[9:0];
                    default: ;
                endcase
            end
            if (dac_we && dac_ok) dac_q[DW'(dac_idx)] <= dac_wval;
        end
    end

    always_comb begin
        unique case (tgt.region)
            RG_CTRL:    rdata = {16'h0000, ctrl_q[ctrl_i]};
            RG_CLUT:    rdata = {clut_q[tgt.bank[0]][clut_i], 8'h00};
            RG_CLUT_SH: rdata = {clut_sh_q[clsh_i], 8'h00};
            RG_FCLR:    rdata = {fclr_q[tgt.bank[0]][fc_i], 8'h00};
            RG_FCLR_SH: rdata = {fclr_sh_q[fc_i], 8'h00};
            RG_WID:     rdata = {22'h0, wid_q[tgt.bank][wid_i]};
            RG_WID_SH:  rdata = {22'h0, wid_sh_q[wid_i]};
            default:    rdata = '0;
        endcase
    end

    assign dac_rval = dac_ok ? dac_q[DW'(dac_idx)] : '0;

endmodule

// File: rtl/ixp_dac_seq.sv
module ixp_dac_seq
    import ixp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        is_ptr,
    input  logic        write,
    input  logic        mode30,
    input  logic [31:0] wdata,
    input  logic [29:0] entry,
    output logic [7:0]  ptr,
    output logic        tbl_we,
    output logic [29:0] tbl_wval,
    output logic [31:0] rd_word
);

    phase_e      phase_q, phase_d;
    logic [7:0]  ptr_q, ptr_d;
    logic [15:0] stage_q, stage_d;
    logic [29:0] hold_q, hold_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_LO;
            ptr_q   <= '0;
            stage_q <= '0;
            hold_q  <= '0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
            stage_q <= stage_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        phase_d  = phase_q;
        ptr_d    = ptr_q;
        stage_d  = stage_q;
        hold_d   = hold_q;
        tbl_we   = 1'b0;
        tbl_wval = {6'h00, wdata[31:8]};
        rd_word  = '0;
        if (acc && is_ptr) begin
            rd_word = {24'h0, ptr_q};
            if (write) begin
                ptr_d   = wdata[7:0];
                phase_d = PH_LO;
            end
        end else if (acc && !mode30) begin
            tbl_we  = write;
            rd_word = {entry[23:0], 8'h00};
            ptr_d   = ptr_q + 8'd1;
            phase_d = PH_LO;
        end else if (acc) begin
            unique case (phase_q)
                PH_LO: begin
                    if (write) stage_d = wdata[15:0];
                    else       hold_d  = entry;
                    rd_word = {16'h0, entry[15:0]};
                    phase_d = PH_HI;
                end
                PH_HI: begin
                    tbl_we   = write;
                    tbl_wval = {wdata[13:0], stage_q};
                    rd_word  = {18'h0, hold_q[29:16]};
                    ptr_d    = ptr_q + 8'd1;
                    phase_d  = PH_LO;
                end
            endcase
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/ixp_port.sv
module ixp_port
    import ixp_pkg::*;
#(
    parameter int CLUT_WORDS = 32,
    parameter int FCLR_WORDS = 6,
    parameter int WID_WORDS  = 80,
    parameter int WID_BANKS  = 5,
    parameter int CTRL_WORDS = 8,
    parameter int DAC_WORDS  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic        bus_sset,
    input  logic [1:0]  bus_sel,
    input  logic [31:0] bus_wdata,
    input  logic        bank_all,
    input  logic        dac_mode30,
    output logic        bus_ack,
    output logic [31:0] bus_rdata
);

    port_sel_e   sel;
    logic [15:0] wptr_q [STATE_SETS];
    logic [15:0] cur_wptr;
    target_t     tgt;
    logic        wide_we;
    logic [31:0] tbl_rdata;

    logic [7:0]  dptr     [STATE_SETS];
    logic        seq_we   [STATE_SETS];
    logic [29:0] seq_wval [STATE_SETS];
    logic [31:0] seq_rd   [STATE_SETS];
    logic [29:0] dac_rval;

    assign sel      = port_sel_e'(bus_sel);
    assign cur_wptr = wptr_q[bus_sset];
    assign wide_we  = bus_valid && bus_write && (sel == SEL_WDATA);

    ixp_decode #(
        .CLUT_WORDS (CLUT_WORDS),
        .FCLR_WORDS (FCLR_WORDS),
        .WID_WORDS  (WID_WORDS),
        .WID_BANKS  (WID_BANKS),
        .CTRL_WORDS (CTRL_WORDS)
    ) u_dec (
        .idx (cur_wptr),
        .tgt (tgt)
    );

    for (genvar g = 0; g < STATE_SETS; g++) begin : g_sset
        ixp_dac_seq u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (bus_valid && (bus_sset == 1'(g)) && bus_sel[1]),
            .is_ptr   (sel == SEL_DPTR),
            .write    (bus_write),
            .mode30   (dac_mode30),
            .wdata    (bus_wdata),
            .entry    (dac_rval),
            .ptr      (dptr[g]),
            .tbl_we   (seq_we[g]),
            .tbl_wval (seq_wval[g]),
            .rd_word  (seq_rd[g])
        );
    end

    ixp_tables #(
        .CLUT_WORDS (CLUT_WORDS),
        .FCLR_WORDS (FCLR_WORDS),
        .WID_WORDS  (WID_WORDS),
        .WID_BANKS  (WID_BANKS),
        .CTRL_WORDS (CTRL_WORDS),
        .DAC_WORDS  (DAC_WORDS)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wide_we),
        .tgt       (tgt),
        .all_banks (bank_all),
        .wdata     (bus_wdata),
        .rdata     (tbl_rdata),
        .dac_we    (seq_we[bus_sset]),
        .dac_idx   (dptr[bus_sset]),
        .dac_wval  (seq_wval[bus_sset]),
        .dac_rval  (dac_rval)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            for (int s = 0; s < STATE_SETS; s++) wptr_q[s] <= '0;
        end else begin
            bus_ack <= bus_valid;
            if (bus_valid) begin
                unique case (sel)
                    SEL_WPTR: begin
                        if (bus_write) wptr_q[bus_sset] <= bus_wdata[15:0];
                        else           bus_rdata <= {16'h0, cur_wptr};
                    end
                    SEL_WDATA: begin
                        wptr_q[bus_sset] <= cur_wptr + 16'd1;
                        if (!bus_write) bus_rdata <= tbl_rdata;
                    end
                    SEL_DPTR, SEL_DDATA: begin
                        if (!bus_write) bus_rdata <= seq_rd[bus_sset];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ixp_port_chk.sv
module ixp_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic        bus_sset,
    input logic [1:0]  bus_sel,
    input logic [15:0] wd_lo,
    input logic        bus_ack,
    input logic [31:0] bus_rdata,
    input logic [15:0] wptr0,
    input logic [7:0]  dptr0
);

    a_r1_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ack);

    a_r1_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ack);

    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> $stable(bus_rdata));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_sel == 2'd0 && !bus_sset) |=> (wptr0 == $past(wd_lo)));

    a_r2_sets_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_sset) |=> ($stable(wptr0) && $stable(dptr0)));

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_sel == 2'd1 && !bus_sset) |=> (wptr0 == $past(wptr0) + 16'd1));

endmodule

bind ixp_port ixp_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_sset  (bus_sset),
    .bus_sel   (bus_sel),
    .wd_lo     (bus_wdata[15:0]),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .wptr0     (wptr_q[0]),
    .dptr0     (dptr[0])
);

// File: tb/ixp_port_tb.sv
module ixp_port_tb;

    localparam int CW = 32;
    localparam int FW = 6;
    localparam int WW = 80;
    localparam int WB = 5;
    localparam int CT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_sset = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bank_all = 1'b0;
    logic        dac_mode30 = 1'b0;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ixp_port #(
        .CLUT_WORDS (CW), .FCLR_WORDS (FW), .WID_WORDS (WW),
        .WID_BANKS (WB), .CTRL_WORDS (CT), .DAC_WORDS (256)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_sset (bus_sset), .bus_sel (bus_sel), .bus_wdata (bus_wdata),
        .bank_all (bank_all), .dac_mode30 (dac_mode30),
        .bus_ack (bus_ack), .bus_rdata (bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic ss, input logic [1:0] sel, input logic wr,
                       input logic [31:0] wd, output logic [31:0] rd);
        bus_valid = 1'b1; bus_sset = ss; bus_sel = sel; bus_write = wr; bus_wdata = wd;
        @(negedge clk);
        rd = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic ss, input logic [1:0] sel, input logic [31:0] wd);
        logic [31:0] d;
        acc(ss, sel, 1'b1, wd, d);
    endtask

    task automatic rd(input logic ss, input logic [1:0] sel, output logic [31:0] r);
        acc(ss, sel, 1'b0, 32'h0, r);
    endtask

    task automatic rd_at(input logic ss, input logic [15:0] idx, output logic [31:0] r);
        wr(ss, 2'd0, {16'h0, idx});
        rd(ss, 2'd1, r);
    endtask

    function automatic logic [31:0] pat(input logic [15:0] idx);
        logic [31:0] h;
        h = {16'h0, idx} * 32'h9E37_79B1;
        return h ^ (h >> 15);
    endfunction

    function automatic logic [31:0] dpat(input int k);
        return (k * 32'h85EB_CA6B) ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [29:0] e30(input int k);
        logic [31:0] h;
        h = (k + 7) * 32'hC2B2_AE35;
        return h[29:0];
    endfunction

    // Expected read of index idx after writing w there (R4..R10)
    function automatic logic [31:0] wexp(input logic [15:0] idx, input logic [31:0] w);
        int off;
        off = int'(idx[7:0]);
        if (idx[15:8] == 8'h20) return (off < CT) ? {16'h0, w[15:0]} : 32'h0;
        if (idx[15:12] == 4'h3) begin
            if (idx[11]) return 32'h0;
            if (idx[9:8] != 2'd3) return (off < CW) ? {w[31:8], 8'h0} : 32'h0;
            return (off < FW) ? {w[31:8], 8'h0} : 32'h0;
        end
        if (idx[15:8] == 8'h40) return (off < CW) ? {w[31:8], 8'h0} : 32'h0;
        if (idx[15:8] == 8'h41) return (off < FW) ? {w[31:8], 8'h0} : 32'h0;
        if (idx[15:11] == 5'b01010)
            return (int'(idx[10:8]) < WB && off < WW) ? {22'h0, w[9:0]} : 32'h0;
        if (idx[15:8] == 8'h58) return (off < WW) ? {22'h0, w[9:0]} : 32'h0;
        return 32'h0;
    endfunction

    function automatic string tag(input logic [15:0] idx, input logic [31:0] e);
        if (e == 32'h0) return "R10 reserved or zero";
        if (idx[15:8] == 8'h20) return "R8 control";
        if (idx[15:12] == 4'h5) return "R7 window-ID";
        if (idx[9:8] == 2'd3) return "R6 R4 fast-clear";
        return "R5 R4 image table";
    endfunction

    initial begin
        logic [31:0] r;
        logic [29:0] eo;
        repeat (3) @(negedge clk);
        // R14 reset state
        chk(bus_ack == 1'b0, "R14 ack", {31'h0, bus_ack}, 32'h0);
        chk(bus_rdata == 32'h0, "R14 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, 2'd0, r);  chk(r == 32'h0, "R14 wide pointer", r, 32'h0);
        chk(bus_ack == 1'b1, "R1 ack after read", {31'h0, bus_ack}, 32'h1);
        @(negedge clk);
        chk(bus_ack == 1'b0, "R1 ack idle", {31'h0, bus_ack}, 32'h0);
        rd(1'b1, 2'd2, r);  chk(r == 32'h0, "R14 converter pointer", r, 32'h0);
        rd_at(1'b0, 16'h2003, r); chk(r == 32'h0, "R14 storage zero", r, 32'h0);

        // R2 pointers per state set
        wr(1'b0, 2'd0, 32'hFFFF_1234);
        wr(1'b1, 2'd0, 32'h0000_BEEF);
        rd(1'b0, 2'd0, r); chk(r == 32'h0000_1234, "R2 pointer ss0", r, 32'h1234);
        rd(1'b1, 2'd0, r); chk(r == 32'h0000_BEEF, "R2 pointer ss1", r, 32'hBEEF);

        // Sweep fill of 0x2000..0x5FFF, then read back (R3..R10)
        wr(1'b0, 2'd0, 32'h2000);
        for (int i = 0; i < 16384; i++) wr(1'b0, 2'd1, pat(16'(32'h2000 + i)));
        chk(bus_ack == 1'b1, "R1 ack after reserved write", {31'h0, bus_ack}, 32'h1);
        rd(1'b0, 2'd0, r); chk(r == 32'h6000, "R3 pointer after stream", r, 32'h6000);
        wr(1'b0, 2'd0, 32'h2000);
        for (int i = 0; i < 16384; i++) begin
            logic [15:0] ix;
            logic [31:0] e;
            ix = 16'(32'h2000 + i);
            e = wexp(ix, pat(ix));
            rd(1'b0, 2'd1, r);
            chk(r == e, tag(ix, e), r, e);
        end

        // R3 wrap
        wr(1'b0, 2'd0, 32'hFFFF);
        rd(1'b0, 2'd1, r); chk(r == 32'h0, "R10 reserved read", r, 32'h0);
        rd(1'b0, 2'd0, r); chk(r == 32'h0, "R3 pointer wrap", r, 32'h0);
        // R2 other state set untouched
        rd(1'b1, 2'd0, r); chk(r == 32'hBEEF, "R2 ss1 untouched", r, 32'hBEEF);

        // R9 write all banks
        bank_all = 1'b1;
        wr(1'b1, 2'd0, 32'h3203);    wr(1'b1, 2'd1, 32'hA1B2_C3D4);
        wr(1'b1, 2'd0, 32'h5346);    wr(1'b1, 2'd1, 32'h0000_02A5);
        wr(1'b1, 2'd0, 32'h3705);    wr(1'b1, 2'd1, 32'h7766_5544);
        bank_all = 1'b0;
        rd_at(1'b1, 16'h3203, r); chk(r == 32'hA1B2_C300, "R9 image bank0", r, 32'hA1B2_C300);
        rd_at(1'b1, 16'h3603, r); chk(r == 32'hA1B2_C300, "R9 image bank1", r, 32'hA1B2_C300);
        rd_at(1'b1, 16'h4003, r); chk(r == wexp(16'h4003, pat(16'h4003)), "R9 image shadow kept", r, wexp(16'h4003, pat(16'h4003)));
        for (int b = 0; b < WB; b++) begin
            rd_at(1'b1, 16'(32'h5046 + b * 32'h100), r);
            chk(r == 32'h2A5, "R9 window-ID bank", r, 32'h2A5);
        end
        rd_at(1'b1, 16'h5846, r); chk(r == wexp(16'h5846, pat(16'h5846)), "R9 window-ID shadow kept", r, wexp(16'h5846, pat(16'h5846)));
        rd_at(1'b1, 16'h3305, r); chk(r == 32'h7766_5500, "R9 fast-clear bank0", r, 32'h7766_5500);
        rd_at(1'b1, 16'h3705, r); chk(r == 32'h7766_5500, "R9 fast-clear bank1", r, 32'h7766_5500);
        wr(1'b1, 2'd0, 32'h3104);    wr(1'b1, 2'd1, 32'h1122_3344);
        rd_at(1'b1, 16'h3104, r); chk(r == 32'h1122_3300, "R9 single bank written", r, 32'h1122_3300);
        rd_at(1'b1, 16'h3504, r); chk(r == wexp(16'h3504, pat(16'h3504)), "R9 other bank kept", r, wexp(16'h3504, pat(16'h3504)));

        // R11 24-bit converter entries
        dac_mode30 = 1'b0;
        wr(1'b0, 2'd2, 32'h0);
        for (int k = 0; k < 256; k++) wr(1'b0, 2'd3, dpat(k));
        rd(1'b0, 2'd2, r); chk(r == 32'h0, "R11 pointer wrap", r, 32'h0);
        for (int k = 0; k < 256; k++) begin
            rd(1'b0, 2'd3, r);
            chk(r == {dpat(k)[31:8], 8'h00}, "R11 24-bit entry", r, {dpat(k)[31:8], 8'h00});
        end

        // R12 30-bit entries across the wrap
        dac_mode30 = 1'b1;
        wr(1'b0, 2'd2, 32'hFE);
        for (int k = 0; k < 4; k++) begin
            wr(1'b0, 2'd3, {16'h0, e30(k)[15:0]});
            if (k == 0) begin
                rd(1'b0, 2'd2, r); chk(r == 32'hFE, "R12 no advance after first half", r, 32'hFE);
            end
            wr(1'b0, 2'd3, {18'h0, e30(k)[29:16]});
        end
        rd(1'b0, 2'd2, r); chk(r == 32'h02, "R12 pointer after four entries", r, 32'h02);
        wr(1'b0, 2'd2, 32'hFE);
        for (int k = 0; k < 4; k++) begin
            rd(1'b0, 2'd3, r); chk(r == {16'h0, e30(k)[15:0]}, "R12 low half", r, {16'h0, e30(k)[15:0]});
            rd(1'b0, 2'd3, r); chk(r == {18'h0, e30(k)[29:16]}, "R12 high half", r, {18'h0, e30(k)[29:16]});
        end

        // R13 coherent 30-bit read while the other state set rewrites the entry
        eo = {6'h00, dpat(16)[31:8]};
        wr(1'b0, 2'd2, 32'h10);
        rd(1'b0, 2'd3, r); chk(r == {16'h0, eo[15:0]}, "R13 first half", r, {16'h0, eo[15:0]});
        wr(1'b1, 2'd2, 32'h10);
        wr(1'b1, 2'd3, {16'h0, e30(9)[15:0]});
        wr(1'b1, 2'd3, {18'h0, e30(9)[29:16]});
        rd(1'b0, 2'd3, r); chk(r == {18'h0, eo[29:16]}, "R13 captured high half", r, {18'h0, eo[29:16]});
        rd(1'b0, 2'd2, r); chk(r == 32'h11, "R12 pointer after read pair", r, 32'h11);
        wr(1'b0, 2'd2, 32'h10);
        rd(1'b0, 2'd3, r); chk(r == {16'h0, e30(9)[15:0]}, "R13 new low", r, {16'h0, e30(9)[15:0]});
        rd(1'b0, 2'd3, r); chk(r == {18'h0, e30(9)[29:16]}, "R13 new high", r, {18'h0, e30(9)[29:16]});

        // R11 pointer write restarts the half sequence
        wr(1'b0, 2'd2, 32'h20);
        wr(1'b0, 2'd3, 32'h0000_AAAA);
        wr(1'b0, 2'd2, 32'h20);
        wr(1'b0, 2'd3, {16'h0, e30(3)[15:0]});
        wr(1'b0, 2'd3, {18'h0, e30(3)[29:16]});
        wr(1'b0, 2'd2, 32'h20);
        rd(1'b0, 2'd3, r); chk(r == {16'h0, e30(3)[15:0]}, "R11 restart low", r, {16'h0, e30(3)[15:0]});
        rd(1'b0, 2'd3, r); chk(r == {18'h0, e30(3)[29:16]}, "R11 restart high", r, {18'h0, e30(3)[29:16]});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule